// File: doc/BRIEF.md
# External Interrupt Input Conditioner

The block takes four asynchronous interrupt pins and turns them into clean requests for an interrupt controller. Each pin first passes through a synchroniser clocked by the system clock. It is then sampled once per instruction cycle, on a one-clock enable tick. A per-pin trigger code selects edge detection or level detection. The pins do not have the same capabilities. Pins 0 and 1 accept single edges and both level polarities. Pins 2 and 3 accept single edges and dual edges, but no level trigger.

Pin 3 also passes through a noise filter. The filter samples at a selectable period of 1, 32 or 128 instruction cycles. It changes its output only after two samples in a row agree. The conditioned levels of pins 2 and 3 are also driven out as event inputs for a neighbouring timer.

Top module: `extint_cond`

## Requirements
- R1: While reset is held and right after it, `irq_req` and `tmr_evt` are all zero.
- R2: Each pin has a 3-bit trigger code in `trig_mode[3i+2:3i]`: 0 off, 1 rising, 2 falling, 3 both edges, 4 high level, 5 low level, 6 and 7 off.
- R3: An edge trigger gives a request pulse exactly one clock wide for each accepted edge of the chosen polarity, and never between ticks.
- R4: On pins 0 and 1, code 4 keeps the request high for as long as the sampled pin is high. Code 5 keeps it high for as long as the sampled pin is low.
- R5: On pins 0 and 1, code 3 (both edges) is not supported and acts as trigger off.
- R6: On pins 2 and 3, code 3 gives one pulse on the rising edge and one pulse on the falling edge.
- R7: On pins 2 and 3, codes 4 and 5 are not supported and act as trigger off.
- R8: Pins are sampled only on clocks where `cyc_tick` is high. On pins 0 to 2, a pulse covering one tick is accepted.
- R9: The filter on pin 3 samples every 1, 32 or 128 ticks, selected by `flt_sel` 0, 1 or 2/3. It changes its output only when two samples in a row agree.
- R10: With `flt_sel`=0, a pin 3 pulse lasting one tick is rejected and a pulse lasting two ticks is accepted.
- R11: With `flt_sel`=1, a pulse of 20 ticks is rejected and a pulse of 64 ticks is accepted. With `flt_sel`=2, a pulse of 100 ticks is rejected and a pulse of 256 ticks is accepted.
- R12: `tmr_evt[0]` is the sampled level of pin 2 and `tmr_evt[1]` is the filtered level of pin 3, whatever the trigger codes are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_tick | input | 1 | Instruction-cycle enable, high for one clock per cycle |
| pin_raw | input | 4 | Raw asynchronous interrupt pins |
| trig_mode | input | 12 | Trigger code per pin, 3 bits each |
| flt_sel | input | 2 | Pin 3 filter sampling period select |
| irq_req | output | 4 | Per-pin request, a pulse for edges or a held level for level triggers |
| tmr_evt | output | 2 | Conditioned pin 2 and pin 3 levels for the timer |

## Verification
The assertions check on every clock that:
- samples and the filter output hold still between their strobes;
- an edge request never appears on a clock without a sample update;
- a disabled or unsupported code never raises a request;
- a level trigger follows the sampled level;
- the filter does not move on a sample that disagrees with the one before it.

Only the bench scenarios can show the pulse counts for each code and pin, and the request levels held during level triggers. The same goes for the minimum pulse widths that each filter period accepts or rejects, and for the timer event levels.

// File: rtl/extint_pkg.sv
package extint_pkg;

    typedef enum logic [2:0] {
        TRG_OFF  = 3'd0,
        TRG_RISE = 3'd1,
        TRG_FALL = 3'd2,
        TRG_BOTH = 3'd3,
        TRG_HIGH = 3'd4,
        TRG_LOW  = 3'd5
    } trg_e;

    // Maps a raw code to the effective trigger, given what the pin supports.
    function automatic trg_e trg_decode(input logic [2:0] code,
                                        input bit allow_lvl,
                                        input bit allow_both);
        trg_e r;
        case (code)
            3'd1:    r = TRG_RISE;
            3'd2:    r = TRG_FALL;
            3'd3:    r = allow_both ? TRG_BOTH : TRG_OFF;
            3'd4:    r = allow_lvl ? TRG_HIGH : TRG_OFF;
            3'd5:    r = allow_lvl ? TRG_LOW : TRG_OFF;
            default: r = TRG_OFF;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/extint_sync.sv
module extint_sync #(
    parameter int W      = 4,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);
    typedef struct packed {
        logic [STAGES-1:0][W-1:0] stg;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.stg[0] = d_in;
        for (int s = 1; s < STAGES; s++) begin
            st_d.stg[s] = st_q.stg[s-1];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign q_out = st_q.stg[STAGES-1];
endmodule

// File: rtl/extint_nfilter.sv
module extint_nfilter #(
    parameter int PER_MID  = 32,
    parameter int PER_LONG = 128
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       din,
    input  logic [1:0] sel,
    output logic       flt
);
    localparam int CW = (PER_LONG > 1) ? $clog2(PER_LONG) : 1;
    localparam logic [CW-1:0] LIM_MID  = CW'(PER_MID - 1);
    localparam logic [CW-1:0] LIM_LONG = CW'(PER_LONG - 1);

    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          prev;
        logic          lvl;
    } flt_t;

    flt_t st_d, st_q;
    logic [CW-1:0] lim;
    logic          strobe;

    always_comb begin
        case (sel)
            2'd0:    lim = '0;
            2'd1:    lim = LIM_MID;
            default: lim = LIM_LONG;
        endcase
        strobe = tick && (st_q.cnt >= lim);
        st_d   = st_q;
        if (tick) st_d.cnt = strobe ? '0 : st_q.cnt + 1'b1;
        if (strobe) begin
            st_d.prev = din;
            if (din == st_q.prev) st_d.lvl = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign flt = st_q.lvl;

    AST_FLT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !strobe |=> $stable(flt)); // R9
    AST_FLT_TWO_AGREE: assert property (@(posedge clk) disable iff (!rst_n)
        (strobe && (din != st_q.prev)) |=> $stable(flt)); // R9
endmodule

// File: rtl/extint_trig.sv
module extint_trig
    import extint_pkg::*;
#(
    parameter bit ALLOW_LVL  = 1'b1,
    parameter bit ALLOW_BOTH = 1'b0
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       upd,
    input  logic       din,
    input  logic [2:0] code,
    output logic       req,
    output logic       lvl
);
    typedef struct packed {
        logic smp;
        logic req;
    } trg_st_t;

    trg_st_t st_d, st_q;
    trg_e    eff;
    logic    rise, fall;

    always_comb begin
        eff  = trg_decode(code, ALLOW_LVL, ALLOW_BOTH);
        st_d = st_q;
        if (upd) st_d.smp = din;
        rise = upd &&  din && !st_q.smp;
        fall = upd && !din &&  st_q.smp;
        case (eff)
            TRG_RISE: st_d.req = rise;
            TRG_FALL: st_d.req = fall;
            TRG_BOTH: st_d.req = rise || fall;
            TRG_HIGH: st_d.req = st_d.smp;
            TRG_LOW:  st_d.req = !st_d.smp;
            default:  st_d.req = 1'b0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req = st_q.req;
    assign lvl = st_q.smp;

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (eff == TRG_OFF) |=> !req); // R5
    AST_EDGE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!upd && (eff == TRG_RISE || eff == TRG_FALL || eff == TRG_BOTH)) |=> !req); // R3
    AST_LVL_TRACK: assert property (@(posedge clk) disable iff (!rst_n)
        (eff == TRG_HIGH) |=> (req == lvl)); // R4
    AST_SAMPLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(lvl)); // R8
endmodule

// File: rtl/extint_cond.sv
module extint_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int PER_MID     = 32,
    parameter int PER_LONG    = 128
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cyc_tick,
    input  logic [3:0]  pin_raw,
    input  logic [11:0] trig_mode,
    input  logic [1:0]  flt_sel,
    output logic [3:0]  irq_req,
    output logic [1:0]  tmr_evt
);
    localparam int NPIN = 4;

    logic [NPIN-1:0] pin_s;
    logic            pin3_f;
    logic [NPIN-1:0] trig_in;
    logic [NPIN-1:0] lvl;

    extint_sync #(.W(NPIN), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_in(pin_raw), .q_out(pin_s)
    );

    extint_nfilter #(.PER_MID(PER_MID), .PER_LONG(PER_LONG)) u_flt (
        .clk(clk), .rst_n(rst_n), .tick(cyc_tick), .din(pin_s[3]),
        .sel(flt_sel), .flt(pin3_f)
    );

    assign trig_in = {pin3_f, pin_s[2:0]};

    for (genvar i = 0; i < NPIN; i++) begin : g_pin
        extint_trig #(.ALLOW_LVL(i < 2), .ALLOW_BOTH(i >= 2)) u_trig (
            .clk(clk), .rst_n(rst_n), .upd(cyc_tick), .din(trig_in[i]),
            .code(trig_mode[3*i +: 3]), .req(irq_req[i]), .lvl(lvl[i])
        );
    end

    assign tmr_evt = {pin3_f, lvl[2]};

    AST_EVT_STEADY: assert property (@(posedge clk) disable iff (!rst_n)
        !cyc_tick |=> $stable(tmr_evt)); // R12
endmodule

// File: tb/sim_extint_cond.sv
module sim_extint_cond;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cyc_tick = 1'b0;
    logic [3:0]  pin_raw = '0;
    logic [11:0] trig_mode = '0;
    logic [1:0]  flt_sel = '0;
    logic [3:0]  irq_req;
    logic [1:0]  tmr_evt;

    int checks = 0;
    int failures = 0;
    int hi_cnt = 0;
    int sel_pin = 0;
    logic counting = 1'b0;
    logic done = 1'b0;

    localparam int TPER = 3;

    extint_cond u0 (
        .clk(clk), .rst_n(rst_n), .cyc_tick(cyc_tick), .pin_raw(pin_raw),
        .trig_mode(trig_mode), .flt_sel(flt_sel), .irq_req(irq_req),
        .tmr_evt(tmr_evt)
    );

    always #10 clk = ~clk;

    initial begin
        forever begin
            for (int k = 0; k < TPER; k++) begin
                @(negedge clk);
                cyc_tick = (k == TPER - 1);
            end
        end
    end

    always @(negedge clk) if (counting) hi_cnt += int'(irq_req[sel_pin]);

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_ticks(input int n);
        repeat (n * TPER) @(negedge clk);
    endtask

    task automatic pulse3(input int len, input int settle, input int exp, input string tag);
        sel_pin = 3; hi_cnt = 0; counting = 1'b1;
        pin_raw[3] = 1'b1; wait_ticks(len);
        pin_raw[3] = 1'b0; wait_ticks(settle);
        counting = 1'b0;
        chk(tag, hi_cnt, exp);
        chk(tag, int'(tmr_evt[1]), 0);
    endtask

    function automatic int exp_pulses(input int p, input int c);
        if (c == 1 || c == 2) return 1;
        if (c == 3 && p >= 2) return 2;
        return 0;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        chk("R1 req in reset", int'(irq_req), 0);
        chk("R1 evt in reset", int'(tmr_evt), 0);
        rst_n = 1'b1;
        wait_ticks(4);
        chk("R1 req after reset", int'(irq_req), 0);
        chk("R1 evt after reset", int'(tmr_evt), 0);

        // R2 R3 R4 R5 R6 R7 R12: sweep of every code on every pin
        for (int p = 0; p < 4; p++) begin
            for (int c = 0; c < 8; c++) begin
                string tg;
                int hi_exp, lo_exp;
                tg = $sformatf("R2 pin%0d code%0d", p, c);
                trig_mode = '0; pin_raw = '0; flt_sel = 2'd0;
                wait_ticks(6);
                trig_mode[3*p +: 3] = 3'(c);
                wait_ticks(2);
                sel_pin = p; hi_cnt = 0; counting = 1'b1;
                pin_raw[p] = 1'b1;
                wait_ticks(15);
                hi_exp = (p < 2 && c == 4) ? 1 : 0;
                chk({tg, " R4 level while high"}, int'(irq_req[p]), hi_exp);
                if (p == 2) chk("R12 pin2 event high", int'(tmr_evt[0]), 1);
                if (p == 3) chk("R12 pin3 event high", int'(tmr_evt[1]), 1);
                pin_raw[p] = 1'b0;
                wait_ticks(15);
                lo_exp = (p < 2 && c == 5) ? 1 : 0;
                chk({tg, " R4 level while low"}, int'(irq_req[p]), lo_exp);
                counting = 1'b0;
                if (!(p < 2 && (c == 4 || c == 5)))
                    chk({tg, " R3 R5 R6 R7 pulse clocks"}, hi_cnt, exp_pulses(p, c));
                if (p >= 2) chk("R12 event low", int'(tmr_evt), 0);
            end
        end

        // R8: a pin 0 pulse exactly one tick long is accepted
        trig_mode = '0; trig_mode[2:0] = 3'd1; wait_ticks(4);
        sel_pin = 0; hi_cnt = 0; counting = 1'b1;
        pin_raw[0] = 1'b1; wait_ticks(1); pin_raw[0] = 1'b0;
        wait_ticks(5); counting = 1'b0;
        chk("R8 one-tick pulse pin0", hi_cnt, 1);

        // R9 R10 R11: filter widths on pin 3, rising trigger
        trig_mode = '0; trig_mode[11:9] = 3'd1;
        flt_sel = 2'd0; wait_ticks(6);
        pulse3(1, 8, 0, "R10 sel0 1 tick rejected");
        pulse3(2, 8, 1, "R10 sel0 2 ticks accepted");
        flt_sel = 2'd1; wait_ticks(70);
        pulse3(20, 100, 0, "R11 sel1 20 ticks rejected");
        pulse3(64, 100, 1, "R11 sel1 64 ticks accepted");
        flt_sel = 2'd2; wait_ticks(300);
        pulse3(100, 400, 0, "R11 sel2 100 ticks rejected");
        pulse3(256, 400, 1, "R9 R11 sel2 256 ticks accepted");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        #(200000 * 20);
        if (!done) begin
            checks++; failures++;
            $display("FAIL watchdog expired actual=timeout expected=done");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule